// File: doc/BRIEF.md
# Block Load Issue Gate

This block sits beside the grouping (G) stage of an in-order pipeline and decides whether the instruction currently at G may issue while block loads are in flight. It tracks how many block loads are waiting in the load buffer. A block load is counted when it is enqueued. It stops being counted when its first data word comes back, because that is the point where it leaves the buffer. When the tracked count reaches its limit of two, every instruction class at G is held, except block stores and empty slots.

The block also turns data-stall cycles of the slower system clock into pipeline bubbles. The system clock is presented as a one-core-cycle strobe. On each strobe during which the data-stall input is high, a countdown is loaded with two or three bubbles. The choice between two and three comes from the configured core-to-system clock ratio. The bubble request stays high while the countdown is non-zero.

Top module: `blk_load_gate`

## Requirements
- R1: A synchronous reset clears the outstanding count and the bubble countdown, so `g_hold` and `bubble_req` read 0 in the cycle after reset.
- R2: An enqueue without a first-word return raises the outstanding count by one. Once two block loads are outstanding, `g_hold` is 1 from the cycle after the second enqueue for the classes ordinary (`g_class`=2'b01) and block load (2'b11).
- R3: A block store (`g_class`=2'b10) and an empty slot (2'b00) are never held, whatever the count.
- R4: A first-word return without an enqueue lowers the count by one, so the hold drops in the cycle after the older block load returns its first word.
- R5: An enqueue and a first-word return in the same cycle leave the count unchanged.
- R6: The count saturates at two. A third enqueue while two are outstanding is lost, so a single return afterwards releases the hold.
- R7: A first-word return with nothing outstanding is ignored, and the count stays at zero.
- R8: With `ratio_sel`=0, a system strobe with data stall high gives exactly 2 cycles of `bubble_req`, starting in the next cycle.
- R9: With `ratio_sel`=1, the same event gives exactly 3 bubble cycles.
- R10: A strobe without data stall, or data stall without a strobe, requests no bubble.
- R11: A stalled strobe that arrives while bubbles remain adds its own bubbles to those still pending, so the total equals the sum over all stalled strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_enq | input | 1 | A block load enters the load buffer |
| first_ret | input | 1 | The first data word of the oldest block load returns |
| g_class | input | 2 | Class of the instruction at G: 00 empty, 01 ordinary, 10 block store, 11 block load |
| sys_tick | input | 1 | One-cycle strobe marking a system clock edge |
| dstall | input | 1 | Data stall from the system side |
| ratio_sel | input | 1 | 0: two bubbles per stalled strobe, 1: three |
| g_hold | output | 1 | Hold the instruction at G |
| bubble_req | output | 1 | Insert a bubble this cycle |

## Verification
A wrong outstanding count is only visible through `g_hold`. A count that is too high holds ordinary instructions while fewer than two loads are in flight. A count that is too low lets them issue. Either error shows in the first cycle that an ordinary class sits at G after the faulty update. A wrong bubble countdown changes how many cycles `bubble_req` stays high after a stalled strobe, so the bench counts those cycles over a window.

// File: rtl/blg_pkg.sv
package blg_pkg;
   typedef enum logic [1:0] {
      CLS_EMPTY  = 2'b00,
      CLS_ORD    = 2'b01,
      CLS_BSTORE = 2'b10,
      CLS_BLOAD  = 2'b11
   } gcls_t;

   localparam int unsigned NUM_CLASSES = 4;
   // classes that must wait at G while the load buffer is full of block loads
   localparam logic [NUM_CLASSES-1:0] DEFAULT_HELD_MASK = 4'b1010;
endpackage

// File: rtl/blg_outstanding.sv
module blg_outstanding #(
   parameter int unsigned MAX_OUT = 2,
   localparam int unsigned CW = $clog2(MAX_OUT + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          enq,
   input  logic          ret,
   output logic [CW-1:0] cnt,
   output logic          full
);
   localparam logic [CW-1:0] CMAX = CW'(MAX_OUT);

   generate
      if (MAX_OUT < 1) begin : g_bad_max
         $error("MAX_OUT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (enq && !ret) begin
         if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
      end else if (ret && !enq) begin
         if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_d;
   end

   assign cnt  = cnt_q;
   assign full = (cnt_q == CMAX);

   assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (cnt_q == '0));
   assert_never_over_R6: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CMAX);
   assert_both_stable_R5: assert property (@(posedge clk) disable iff (rst)
      (enq && ret) |=> $stable(cnt_q));
   assert_release_R4: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == CMAX && ret && !enq) |=> !full);
   assert_empty_ret_R7: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == '0 && ret && !enq) |=> (cnt_q == '0));
endmodule

// File: rtl/blg_issue_hold.sv
module blg_issue_hold
   import blg_pkg::*;
#(
   parameter logic [NUM_CLASSES-1:0] HELD_MASK = DEFAULT_HELD_MASK
) (
   input  logic  full,
   input  gcls_t cls,
   output logic  hold
);
   logic [NUM_CLASSES-1:0] held_v;

   generate
      for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_cls
         assign held_v[i] = HELD_MASK[i];
      end
      if (HELD_MASK[CLS_BSTORE]) begin : g_bad_mask
         $error("block stores must stay exempt from the hold");
      end
   endgenerate

   assign hold = full & held_v[cls];

   always_comb begin
      if (cls == CLS_BSTORE) assert_exempt_R3: assert (!hold);
   end
endmodule

// File: rtl/blg_bubble_gen.sv
module blg_bubble_gen #(
   parameter int unsigned BUB_LO = 2,
   parameter int unsigned BUB_HI = 3,
   localparam int unsigned BW = $clog2(2 * BUB_HI + 1) + 1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic stall,
   input  logic ratio_sel,
   output logic bubble
);
   localparam logic [BW:0]   SAT  = {1'b0, {BW{1'b1}}};
   localparam logic [BW-1:0] N_LO = BW'(BUB_LO);
   localparam logic [BW-1:0] N_HI = BW'(BUB_HI);

   generate
      if (BUB_LO < 1 || BUB_HI < BUB_LO) begin : g_bad_bub
         $error("bubble counts must satisfy 1 <= BUB_LO <= BUB_HI");
      end
   endgenerate

   logic [BW-1:0] cnt_q;
   logic [BW-1:0] dec, nb;
   logic [BW:0]   sum;
   logic          load;

   assign load = tick & stall;
   assign nb   = ratio_sel ? N_HI : N_LO;
   assign dec  = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
   assign sum  = {1'b0, dec} + (load ? {1'b0, nb} : '0);

   always_ff @(posedge clk) begin
      if (rst)           cnt_q <= '0;
      else if (sum > SAT) cnt_q <= SAT[BW-1:0];
      else                cnt_q <= sum[BW-1:0];
   end

   assign bubble = (cnt_q != '0);

   assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !bubble);
   assert_load_starts_R8: assert property (@(posedge clk) disable iff (rst)
      load |=> bubble);
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      (cnt_q <= 1 && !load) |=> !bubble);
   assert_drain_R9: assert property (@(posedge clk) disable iff (rst)
      (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
   assert_accumulate_R11: assert property (@(posedge clk) disable iff (rst)
      (cnt_q > 1 && load) |=> (cnt_q > $past(nb)));
endmodule

// File: rtl/blk_load_gate.sv
module blk_load_gate
   import blg_pkg::*;
#(
   parameter int unsigned MAX_OUT = 2,
   parameter int unsigned BUB_LO  = 2,
   parameter int unsigned BUB_HI  = 3
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       blk_enq,
   input  logic       first_ret,
   input  logic [1:0] g_class,
   input  logic       sys_tick,
   input  logic       dstall,
   input  logic       ratio_sel,
   output logic       g_hold,
   output logic       bubble_req
);
   localparam int unsigned CW = $clog2(MAX_OUT + 1);

   logic [CW-1:0] out_cnt;
   logic          out_full;
   gcls_t         cls;

   assign cls = gcls_t'(g_class);

   blg_outstanding #(.MAX_OUT(MAX_OUT)) u_out (
      .clk  (clk),
      .rst  (rst),
      .enq  (blk_enq),
      .ret  (first_ret),
      .cnt  (out_cnt),
      .full (out_full)
   );

   blg_issue_hold #(.HELD_MASK(DEFAULT_HELD_MASK)) u_hold (
      .full (out_full),
      .cls  (cls),
      .hold (g_hold)
   );

   blg_bubble_gen #(.BUB_LO(BUB_LO), .BUB_HI(BUB_HI)) u_bub (
      .clk       (clk),
      .rst       (rst),
      .tick      (sys_tick),
      .stall     (dstall),
      .ratio_sel (ratio_sel),
      .bubble    (bubble_req)
   );

   assert_hold_needs_full_R2: assert property (@(posedge clk) disable iff (rst)
      g_hold |-> (out_cnt == CW'(MAX_OUT)));
   assert_empty_free_R3: assert property (@(posedge clk) disable iff (rst)
      (g_class == 2'b00 || g_class == 2'b10) |-> !g_hold);
endmodule

// File: tb/test_blk_load_gate.sv
module test_blk_load_gate;
   logic       clk = 0;
   logic       rst = 1;
   logic       blk_enq = 0, first_ret = 0, sys_tick = 0, dstall = 0, ratio_sel = 0;
   logic [1:0] g_class = 2'b01;
   logic       g_hold, bubble_req;
   int         errors = 0, checks = 0;
   bit         done = 0;

   always #2 clk = ~clk;

   blk_load_gate i_blk_load_gate (
      .clk(clk), .rst(rst), .blk_enq(blk_enq), .first_ret(first_ret),
      .g_class(g_class), .sys_tick(sys_tick), .dstall(dstall),
      .ratio_sel(ratio_sel), .g_hold(g_hold), .bubble_req(bubble_req)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one edge consuming current inputs, pulses cleared after it
   task automatic step();
      @(posedge clk); #1;
      blk_enq = 0; first_ret = 0; sys_tick = 0;
   endtask

   task automatic count_bubbles(input int win, output int n);
      n = 0;
      for (int k = 0; k < win; k++) begin
         if (bubble_req) n++;
         step();
      end
   endtask

   initial begin
      int n;
      int m;
      logic [15:0] lf;
      rst = 1; step(); step();
      chk("R1 hold", g_hold, 0);
      chk("R1 bubble", bubble_req, 0);
      rst = 0;

      // R2: two enqueues hold an ordinary instruction
      g_class = 2'b01;
      blk_enq = 1; step(); chk("R2 one out", g_hold, 0);
      blk_enq = 1; step(); chk("R2 two out", g_hold, 1);
      g_class = 2'b11; #0 chk("R2 bload held", g_hold, 1);
      // R3: exempt classes
      g_class = 2'b10; #1 chk("R3 bstore", g_hold, 0);
      g_class = 2'b00; #1 chk("R3 empty", g_hold, 0);
      g_class = 2'b01;
      // R5: both together
      blk_enq = 1; first_ret = 1; step(); chk("R5 stable", g_hold, 1);
      // R6: third enqueue lost
      blk_enq = 1; step(); chk("R6 still full", g_hold, 1);
      // R4: one return releases
      first_ret = 1; step(); chk("R4 release", g_hold, 0);
      first_ret = 1; step(); chk("R4 to zero", g_hold, 0);
      // R7: return at zero ignored
      first_ret = 1; step();
      blk_enq = 1; step(); chk("R7 floor one", g_hold, 0);
      blk_enq = 1; step(); chk("R7 floor two", g_hold, 1);
      first_ret = 1; step(); first_ret = 1; step();

      // R2..R7 sweep against arithmetic model
      m = 0; lf = 16'hACE1;
      for (int c = 0; c < 400; c++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         blk_enq = lf[0]; first_ret = lf[3]; g_class = lf[6:5];
         if (blk_enq && !first_ret) m = (m < 2) ? m + 1 : 2;
         else if (first_ret && !blk_enq) m = (m > 0) ? m - 1 : 0;
         step();
         chk("R2-model hold", g_hold,
             (m == 2 && (g_class == 2'b01 || g_class == 2'b11)) ? 1 : 0);
      end
      while (m > 0) begin first_ret = 1; step(); m--; end

      // R8 / R9 single stalled strobe
      for (int r = 0; r < 2; r++) begin
         ratio_sel = r[0]; sys_tick = 1; dstall = 1; step(); dstall = 0;
         count_bubbles(8, n);
         chk(r == 0 ? "R8 two bubbles" : "R9 three bubbles", n, r == 0 ? 2 : 3);
      end
      // R8 start in next cycle
      ratio_sel = 0; sys_tick = 1; dstall = 1; step(); dstall = 0;
      chk("R8 starts next", bubble_req, 1);
      count_bubbles(6, n);
      // R10 tick without stall, stall without tick
      sys_tick = 1; dstall = 0; step(); chk("R10 tick only", bubble_req, 0);
      dstall = 1; step(); step(); chk("R10 stall only", bubble_req, 0);
      dstall = 0;
      // R11 overlapping strobes, sweep gap and ratio
      for (int r = 0; r < 2; r++) begin
         for (int gap = 1; gap <= 4; gap++) begin
            ratio_sel = r[0];
            n = 0;
            dstall = 1; sys_tick = 1;
            if (bubble_req) n++;
            step();
            for (int k = 1; k < gap; k++) begin
               dstall = 0; if (bubble_req) n++; step();
            end
            dstall = 1; sys_tick = 1; if (bubble_req) n++; step(); dstall = 0;
            for (int k = 0; k < 12; k++) begin
               if (bubble_req) n++; step();
            end
            chk("R11 accumulated", n, 2 * (r == 0 ? 2 : 3));
         end
      end

      // R1 mid-run reset
      blk_enq = 1; step(); blk_enq = 1; step();
      sys_tick = 1; dstall = 1; ratio_sel = 1; step(); dstall = 0;
      rst = 1; step(); rst = 0; g_class = 2'b01;
      chk("R1 hold cleared", g_hold, 0);
      chk("R1 bubble cleared", bubble_req, 0);

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule